// File: doc/BRIEF.md
# Signed Array Multiplier with Sign-Correcting Partial Products

This block multiplies two signed two's-complement operands of WIDTH bits each and returns the full 2·WIDTH-bit signed product. It has no multiplication operator and no subtractor. Each partial-product bit is an AND of one bit from each operand. When exactly one of the two bits is a sign bit, that AND output is inverted. A constant row supplies the two correction ones. One lies at column WIDTH and the other at the top column, 2·WIDTH−1. With these changes every row can be added as a positive quantity.

The rows are folded pairwise by a regular carry-save array of full adders, which leaves a sum vector and a carry vector. A carry-lookahead adder built from 4-bit groups then merges the two vectors into the product. A parameter decides whether the product goes through one output register or leaves the block combinationally. The register is the default, and its reset clears it to zero.

Top module: `bw_mult`

## Requirements
- R1: For every pair of signed WIDTH-bit operands, the product output equals the exact signed product as a 2·WIDTH-bit two's-complement value. The carry-lookahead stage must return the modular sum of the carry-save sum and carry vectors.
- R2: The most negative operand times itself yields +2^(2·WIDTH−2). For WIDTH = 8, −128 × −128 gives 16384, which is 0x4000.
- R3: When either operand is zero, the product is zero whatever the other operand is.
- R4: When both operands are nonzero, the product's top bit equals the XOR of the two operand sign bits.
- R5: Multiplying by +1 returns the other operand sign-extended to 2·WIDTH bits. Multiplying by −1 returns its negation, including −128 × −1 = +128 (0x0080) for WIDTH = 8.
- R6: With the output register enabled (REG_OUT = 1), the product changes only at a rising clock edge. After that edge it shows the result for the operands present at the edge, and between edges it keeps its previous value.
- R7: While rst_n is low, the registered product is zero at every rising edge, whatever the operands are.
- R8: Swapping the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | WIDTH | First signed operand (multiplicand) |
| op_b | input | WIDTH | Second signed operand (multiplier) |
| product | output | 2·WIDTH | Signed product |

## Verification
The correction-constant path is the case most easily left untested. Its top-column one must cancel exactly against the carries when both operands are at their most negative value. In that case every inverted mixed term is 1 and the result needs the top bit clear. Mixed-sign operands near −1 and the most negative value push carries through every 4-bit lookahead group. These cases are all covered because the bench sweeps every one of the 65536 operand pairs for WIDTH = 8 through the registered path. Separate directed tasks also repeat the −128 corners and the ±1 corners, and they check when the register updates relative to the clock.

// File: rtl/bw_pkg.sv
package bw_pkg;

  // Partial-product cell: plain AND, inverted when exactly one sign bit is involved.
  function automatic logic pp_cell(input logic a_bit, input logic b_bit, input logic mixed);
    logic p;
    p = a_bit & b_bit;
    return mixed ? ~p : p;
  endfunction

  // Full-adder arithmetic, returned as {carry, sum}.
  function automatic logic [1:0] fa_fn(input logic x, input logic y, input logic z);
    logic s;
    logic c;
    s = x ^ y ^ z;
    c = (x & y) | (x & z) | (y & z);
    return {c, s};
  endfunction

  // Four-bit lookahead group, returned as {carry_out, sum[3:0]}.
  function automatic logic [4:0] cla4_fn(input logic [3:0] x, input logic [3:0] y, input logic cin);
    logic [3:0] g;
    logic [3:0] p;
    logic [4:0] c;
    g = x & y;
    p = x ^ y;
    c[0] = cin;
    c[1] = g[0] | (p[0] & cin);
    c[2] = g[1] | (g[0] & p[1]) | (cin & p[0] & p[1]);
    c[3] = g[2] | (g[1] & p[2]) | (g[0] & p[1] & p[2]) | (cin & p[0] & p[1] & p[2]);
    c[4] = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3]) | (g[0] & p[1] & p[2] & p[3])
         | (cin & p[0] & p[1] & p[2] & p[3]);
    return {c[4], p ^ c[3:0]};
  endfunction

endpackage

// File: rtl/bw_fa.sv
module bw_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  import bw_pkg::*;

  logic [1:0] res;

  assign res = fa_fn(x, y, z);
  assign s   = res[0];
  assign c   = res[1];
endmodule

// File: rtl/bw_pp_gen.sv
module bw_pp_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]               mcand,
  input  logic [WIDTH-1:0]               mplier,
  output logic [WIDTH:0][2*WIDTH-1:0]    rows
);
  import bw_pkg::*;

  localparam int PW  = 2 * WIDTH;
  localparam int MSB = WIDTH - 1;

  // Rows 0..WIDTH-1 hold shifted partial products; row WIDTH holds the correction ones.
  always_comb begin
    rows = '0;
    for (int k = 0; k < WIDTH; k++) begin
      for (int i = 0; i < WIDTH; i++) begin
        rows[k][i+k] = pp_cell(mcand[i], mplier[k], (i == MSB) != (k == MSB));
      end
    end
    rows[WIDTH][WIDTH]  = 1'b1;
    rows[WIDTH][PW-1]   = 1'b1;
  end
endmodule

// File: rtl/bw_csa_array.sv
module bw_csa_array #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0][2*WIDTH-1:0] rows,
  output logic [2*WIDTH-1:0]          sum_vec,
  output logic [2*WIDTH-1:0]          carry_vec
);
  localparam int PW     = 2 * WIDTH;
  localparam int STAGES = WIDTH - 1;

  logic [PW-1:0] st_s [0:STAGES];
  logic [PW-1:0] st_c [0:STAGES];

  assign st_s[0] = rows[0];
  assign st_c[0] = rows[1];

  // Each stage folds one further row into the running sum/carry pair.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [PW-1:0] fa_cy;
    logic [PW-1:0] fa_sm;
    for (genvar b = 0; b < PW; b++) begin : g_bit
      bw_fa u_fa (
        .x (st_s[s][b]),
        .y (st_c[s][b]),
        .z (rows[s+2][b]),
        .s (fa_sm[b]),
        .c (fa_cy[b])
      );
    end
    assign st_s[s+1] = fa_sm;
    assign st_c[s+1] = {fa_cy[PW-2:0], 1'b0};
  end

  assign sum_vec   = st_s[STAGES];
  assign carry_vec = st_c[STAGES];
endmodule

// File: rtl/bw_cla.sv
module bw_cla #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  import bw_pkg::*;

  localparam int GROUPS = (W + 3) / 4;
  localparam int GW     = GROUPS * 4;

  logic [GW-1:0]   xp;
  logic [GW-1:0]   yp;
  logic [GW-1:0]   sp;
  logic [GROUPS:0] gc;

  assign xp    = GW'(x);
  assign yp    = GW'(y);
  assign gc[0] = 1'b0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [4:0] r;
    assign r            = cla4_fn(xp[4*g +: 4], yp[4*g +: 4], gc[g]);
    assign sp[4*g +: 4] = r[3:0];
    assign gc[g+1]      = r[4];
  end

  assign sum = sp[W-1:0];
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  output logic [2*WIDTH-1:0]   product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH:0][PW-1:0] pp_rows;
  logic [PW-1:0]          cs_sum;
  logic [PW-1:0]          cs_carry;
  logic [PW-1:0]          mul_raw;

  bw_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .mcand  (op_a),
    .mplier (op_b),
    .rows   (pp_rows)
  );

  bw_csa_array #(.WIDTH(WIDTH)) u_csa (
    .rows      (pp_rows),
    .sum_vec   (cs_sum),
    .carry_vec (cs_carry)
  );

  bw_cla #(.W(PW)) u_cpa (
    .x   (cs_sum),
    .y   (cs_carry),
    .sum (mul_raw)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= mul_raw;
    end
    assign product = prod_q;

    // R7: reset clears the output register
    assert_reset_clear_R7: assert property (@(posedge clk) !rst_n |=> (product == '0));
  end else begin : g_comb
    assign product = mul_raw;
  end

  // R1: lookahead stage resolves the carry-save pair modulo 2^PW
  assert_cpa_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(cs_sum + cs_carry) == mul_raw);

  // R3: a zero operand forces a zero result
  assert_zero_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == '0 || op_b == '0) |-> (mul_raw == '0));

  // R4: result sign follows the operand signs when neither is zero
  assert_sign_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != '0 && op_b != '0) |-> (mul_raw[PW-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1])));

  // R5: multiply by +1 returns the sign-extended multiplicand
  assert_unit_mult_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_b == WIDTH'(1)) |-> (mul_raw == {{WIDTH{op_a[WIDTH-1]}}, op_a}));
endmodule

// File: tb/bw_mult_tb.sv
`timescale 1ns/1ps
module bw_mult_tb_top;
  localparam int WIDTH = 8;
  localparam int PW    = 2 * WIDTH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic [PW-1:0]    product;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bw_mult #(.WIDTH(WIDTH), .REG_OUT(1'b1)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    int sa;
    int sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: product=%h expected=%h (a=%h b=%h)", req, act, exp, op_a, op_b);
    end
  endtask

  // Drive at the falling edge, then sample just after the capturing rising edge.
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_a  = 8'h7F;
    op_b  = 8'h7F;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset holds zero", product, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(WIDTH'(i), WIDTH'(j));
        chk("R1 exhaustive", product, ref_mul(WIDTH'(i), WIDTH'(j)));
      end
    end
  endtask

  task automatic t_corners;
    apply(8'h80, 8'h80);
    chk("R2 min*min", product, 16'h4000);
    apply(8'h00, 8'h80);
    chk("R3 zero*min", product, 16'h0000);
    apply(8'h7F, 8'h00);
    chk("R3 max*zero", product, 16'h0000);
    apply(8'h80, 8'h7F);
    chk("R4 sign min*max", product, 16'hC080);
    apply(8'hFF, 8'hFF);
    chk("R4 sign -1*-1", product, 16'h0001);
    apply(8'h85, 8'h01);
    chk("R5 times +1", product, 16'hFF85);
    apply(8'h80, 8'hFF);
    chk("R5 min times -1", product, 16'h0080);
    apply(8'h7F, 8'hFF);
    chk("R5 max times -1", product, 16'hFF81);
  endtask

  task automatic t_commute;
    logic [PW-1:0] first;
    for (int k = 0; k < 16; k++) begin
      apply(WIDTH'(k * 37 + 3), WIDTH'(k * 91 + 128));
      first = product;
      apply(WIDTH'(k * 91 + 128), WIDTH'(k * 37 + 3));
      chk("R8 swap operands", product, first);
    end
  endtask

  task automatic t_latency;
    apply(8'h03, 8'h05);
    chk("R6 settled", product, 16'h000F);
    @(negedge clk);
    op_a = 8'hFE;
    op_b = 8'h07;
    #1;
    chk("R6 holds before edge", product, 16'h000F);
    @(posedge clk);
    #1;
    chk("R6 updates after edge", product, 16'hFFF2);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 reset mid-run", product, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_corners();
    t_commute();
    t_latency();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule